// File: doc/BRIEF.md
# Serial Flash Command and Status Controller

This block is the slave-side command engine of a small serial flash device. A host drives a four-wire serial bus in clock mode 0 or mode 3. While chip select is low the block shifts in an 8-bit opcode, MSB first, on rising clock edges, followed by any address or data bytes. It then sets or clears the write enable latch, streams the status register back, rewrites the protection bits, or asks the array for a program or erase cycle.

All bus pins are sampled by the block's own system clock through a synchronizer. Bus edges are detected from the synchronized levels, so the bus clock must run several times slower than the system clock. The memory array and its page buffer sit outside the block. Page-program data bytes leave on a byte-write port, each tagged with its column in the page. A program or erase cycle is requested by holding `arr_req` high until the array returns an `arr_ack` pulse.

Top module: `spi_flash_ctrl`

## Requirements
- R1: After reset the status register reads 00h, `arr_req` is low and `spi_miso_oe` is low.
- R2: Bus input is sampled on rising bus clock edges, MSB first, and the block behaves the same in mode 0 (clock idles low) and mode 3 (clock idles high).
- R3: Opcode 06h sets the write enable latch (status bit 1) and opcode 04h clears it. Both take effect on the eighth bit, and any clocks after it are ignored until chip select rises.
- R4: Opcode 05h returns the status register on `spi_miso`, MSB first. Each bit is driven after a falling bus clock edge. The register is repeated for as long as clocking continues.
- R5: `spi_miso_oe` is high only from the first falling edge after a 05h opcode until chip select rises.
- R6: Opcode 01h with exactly one data byte (16 bits in total) loads status bit 7 (write-disable flag) and bits 3:2 (protect bits) from that byte, and clears the write enable latch. Any other frame length leaves the register unchanged.
- R7: While the write-disable flag is 1 and `wp_n` is low, 01h is not executed: the protect bits, the flag and the write enable latch all keep their values.
- R8: Opcode 02h with a 3-byte address and one or more data bytes does three things. It pulses `pg_clr` once the address is accepted. It presents each data byte on `pg_wr`/`pg_col`/`pg_data`, with the column starting at the address's low bits and wrapping within the page. If chip select rises on a byte boundary, it raises `arr_req` with `arr_op`=1 and the start address; a rise in mid-byte requests nothing.
- R9: Opcode D8h with exactly a 3-byte address requests `arr_op`=2 at that address. Opcode C7h with exactly 8 bits requests `arr_op`=3, and only when both protect bits are 0.
- R10: The protect bits lock the top quarter (01), the top half (10) or all (11) of the array, with the quarter selected by the two top address bits. Program or sector erase aimed at a locked quarter issues no request.
- R11: Status bit 0 is high from the request until `arr_ack`. At `arr_ack` both bit 0 and the write enable latch clear. While bit 0 is high, every opcode except 05h is ignored.
- R12: An unknown opcode is ignored together with all bits that follow it until chip select rises.
- R13: Opcodes 01h, 02h, D8h and C7h are ignored unless the write enable latch is set, and such a rejected command leaves the latch set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Bus clock |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for `spi_miso`; pad is high-impedance when low |
| wp_n | input | 1 | Active-low write-protect pin |
| arr_req | output | 1 | Program/erase request, held until acknowledged |
| arr_op | output | 2 | 1 program, 2 sector erase, 3 bulk erase |
| arr_addr | output | ADDR_W | Start address of the request (0 for bulk erase) |
| arr_ack | input | 1 | One-cycle pulse when the array cycle is done |
| pg_clr | output | 1 | Pulse: discard the page buffer |
| pg_wr | output | 1 | Pulse: page buffer byte write |
| pg_col | output | PAGE_W | Column of the written byte |
| pg_data | output | 8 | Byte to write |

## Verification
The bench targets frame-length boundaries. These are a status write with one extra bit, a bulk erase with a ninth bit, and a program frame cut three bits into a data byte. A controller that decides on byte counts alone, or on the opcode alone, would start an array cycle or rewrite the status in those cases. It also sweeps the write-protect pin against the write-disable flag, where a missing check lets software unlock a hardware-locked register. It sends opcodes while busy and checks that the latch still reads set. A program that crosses the page end must wrap its column to zero rather than carry into the page number. Status reads in mode 3 cover two consecutive bytes, which exposes a shifter that does not reload or that moves on the wrong edge.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_WRDI = 8'h04;
  localparam logic [7:0] OPC_RDSR = 8'h05;
  localparam logic [7:0] OPC_WRSR = 8'h01;
  localparam logic [7:0] OPC_PROG = 8'h02;
  localparam logic [7:0] OPC_SERS = 8'hD8;
  localparam logic [7:0] OPC_BERS = 8'hC7;

  typedef enum logic [1:0] {
    AOP_NONE   = 2'd0,
    AOP_PROG   = 2'd1,
    AOP_SERASE = 2'd2,
    AOP_BERASE = 2'd3
  } arr_op_e;

  typedef enum logic [2:0] {
    ST_WAIT,   // ignore bits until deselect
    ST_OPC,    // collecting opcode
    ST_ADDR,   // collecting address or status byte
    ST_DATA,   // complete frame pending, or program data
    ST_RDSR    // streaming status
  } eng_state_e;

  // quarter index = two top address bits; returns 1 if that quarter is locked
  function automatic logic quarter_locked(input logic [1:0] quarter, input logic [1:0] bp);
    case (bp)
      2'b00:   quarter_locked = 1'b0;
      2'b01:   quarter_locked = (quarter == 2'b11);
      2'b10:   quarter_locked = quarter[1];
      default: quarter_locked = 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] status_pack(input logic srwd, input logic [1:0] bp,
                                             input logic wel, input logic wip);
    status_pack = {srwd, 3'b000, bp, wel, wip};
  endfunction

  function automatic logic needs_wel(input logic [7:0] opc);
    needs_wel = (opc == OPC_WRSR) || (opc == OPC_PROG) ||
                (opc == OPC_SERS) || (opc == OPC_BERS);
  endfunction

endpackage

// File: rtl/sfc_spi_sync.sv
module sfc_spi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  input  logic wp_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_fall,
  output logic cs_rise,
  output logic cs_act,
  output logic mosi_s,
  output logic wp_n_s
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sck_p, cs_p, mosi_p, wp_p;
  logic          sck_d, cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p  <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
      wp_p   <= '1;
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sck_p  <= {sck_p[LAST-1:0], spi_sck};
      cs_p   <= {cs_p[LAST-1:0], spi_cs_n};
      mosi_p <= {mosi_p[LAST-1:0], spi_mosi};
      wp_p   <= {wp_p[LAST-1:0], wp_n};
      sck_d  <= sck_p[LAST];
      cs_d   <= cs_p[LAST];
    end
  end

  assign cs_act   = !cs_p[LAST];
  assign sck_rise = cs_act &&  sck_p[LAST] && !sck_d;
  assign sck_fall = cs_act && !sck_p[LAST] &&  sck_d;
  assign cs_fall  = !cs_p[LAST] &&  cs_d;
  assign cs_rise  =  cs_p[LAST] && !cs_d;
  assign mosi_s   = mosi_p[LAST];
  assign wp_n_s   = wp_p[LAST];

endmodule

// File: rtl/sfc_cmd_engine.sv
module sfc_cmd_engine
  import sfc_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              cs_act,
  input  logic              mosi_s,
  input  logic              wp_n_s,
  input  logic              arr_ack,
  output logic [7:0]        status,
  output logic              rdsr_active,
  output logic              arr_req,
  output logic [1:0]        arr_op,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              pg_clr,
  output logic              pg_wr,
  output logic [PAGE_W-1:0] pg_col,
  output logic [7:0]        pg_data
);
  localparam logic [2:0] BCNT_SAT  = 3'd5;  // opcode + 3 address + >=1 data
  localparam logic [2:0] BCNT_ADDR = 3'd3;

  // framing
  logic [2:0] bit_q, bcnt_q;
  logic [6:0] sh_q;
  logic [7:0] byte_in;
  logic       byte_evt;

  assign byte_in  = {sh_q, mosi_s};
  assign byte_evt = sck_rise && (bit_q == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      bcnt_q <= '0;
      sh_q   <= '0;
    end else if (cs_fall) begin
      bit_q  <= '0;
      bcnt_q <= '0;
    end else if (sck_rise) begin
      bit_q <= bit_q + 3'd1;
      sh_q  <= byte_in[6:0];
      if (byte_evt && bcnt_q != BCNT_SAT) bcnt_q <= bcnt_q + 3'd1;
    end
  end

  // status register
  logic       srwd_q, wel_q, wip_q;
  logic [1:0] bp_q;

  // command state
  eng_state_e        state_q;
  logic [7:0]        cmd_q, wrsr_q;
  logic [ADDR_W-1:0] addr_q, addr_nxt;
  logic [PAGE_W-1:0] col_q;

  assign addr_nxt = {addr_q[ADDR_W-9:0], byte_in};

  // named internal events
  logic opc_evt, addr_done_evt, exec_evt, wrsr_ok, start_evt, done_evt, hw_locked;

  assign opc_evt       = byte_evt && (state_q == ST_OPC);
  assign addr_done_evt = byte_evt && (state_q == ST_ADDR) && (cmd_q != OPC_WRSR) &&
                         (bcnt_q == BCNT_ADDR);
  assign hw_locked     = srwd_q && !wp_n_s;
  assign exec_evt      = cs_rise && (state_q == ST_DATA) && (bit_q == 3'd0) &&
                         ((cmd_q != OPC_PROG) || (bcnt_q == BCNT_SAT));
  assign wrsr_ok       = exec_evt && (cmd_q == OPC_WRSR) && !hw_locked;
  assign start_evt     = exec_evt && (cmd_q != OPC_WRSR);
  assign done_evt      = arr_ack && wip_q;

  function automatic eng_state_e opc_next(input logic [7:0] opc, input logic busy,
                                          input logic wel, input logic [1:0] bp);
    if (opc == OPC_RDSR)                          opc_next = ST_RDSR;
    else if (!needs_wel(opc) || busy || !wel)     opc_next = ST_WAIT;
    else if (opc == OPC_BERS)                     opc_next = (bp == 2'b00) ? ST_DATA : ST_WAIT;
    else                                          opc_next = ST_ADDR;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      cmd_q   <= '0;
      wrsr_q  <= '0;
      addr_q  <= '0;
      col_q   <= '0;
      pg_clr  <= 1'b0;
      pg_wr   <= 1'b0;
      pg_col  <= '0;
      pg_data <= '0;
    end else begin
      pg_clr <= 1'b0;
      pg_wr  <= 1'b0;
      if (cs_fall) begin
        state_q <= ST_OPC;
      end else if (byte_evt) begin
        case (state_q)
          ST_OPC: begin
            cmd_q   <= byte_in;
            state_q <= opc_next(byte_in, wip_q, wel_q, bp_q);
          end
          ST_ADDR: begin
            if (cmd_q == OPC_WRSR) begin
              wrsr_q  <= byte_in;
              state_q <= ST_DATA;
            end else begin
              addr_q <= addr_nxt;
              if (bcnt_q == BCNT_ADDR) begin
                col_q <= addr_nxt[PAGE_W-1:0];
                if (quarter_locked(addr_nxt[ADDR_W-1 -: 2], bp_q)) begin
                  state_q <= ST_WAIT;
                end else begin
                  state_q <= ST_DATA;
                  pg_clr  <= (cmd_q == OPC_PROG);
                end
              end
            end
          end
          ST_DATA: begin
            if (cmd_q == OPC_PROG) begin
              pg_wr   <= 1'b1;
              pg_col  <= col_q;
              pg_data <= byte_in;
              col_q   <= col_q + 1'b1;
            end else begin
              state_q <= ST_WAIT;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // status and array request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srwd_q   <= 1'b0;
      bp_q     <= 2'b00;
      wel_q    <= 1'b0;
      wip_q    <= 1'b0;
      arr_op   <= AOP_NONE;
      arr_addr <= '0;
    end else begin
      if (opc_evt && !wip_q) begin
        if (byte_in == OPC_WREN) wel_q <= 1'b1;
        if (byte_in == OPC_WRDI) wel_q <= 1'b0;
      end
      if (wrsr_ok) begin
        srwd_q <= wrsr_q[7];
        bp_q   <= wrsr_q[3:2];
        wel_q  <= 1'b0;
      end
      if (start_evt) begin
        wip_q <= 1'b1;
        case (cmd_q)
          OPC_PROG: begin arr_op <= AOP_PROG;   arr_addr <= addr_q; end
          OPC_SERS: begin arr_op <= AOP_SERASE; arr_addr <= addr_q; end
          default:  begin arr_op <= AOP_BERASE; arr_addr <= '0;     end
        endcase
      end
      if (done_evt) begin
        wip_q  <= 1'b0;
        wel_q  <= 1'b0;
        arr_op <= AOP_NONE;
      end
    end
  end

  assign status      = status_pack(srwd_q, bp_q, wel_q, wip_q);
  assign rdsr_active = cs_act && (state_q == ST_RDSR);
  assign arr_req     = wip_q;

  AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> wel_q);  // R13
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> !wip_q);  // R11
  AST_BULK_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && cmd_q == OPC_BERS) |-> (bp_q == 2'b00));  // R9
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (!wel_q && !arr_req));  // R11
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_req && !arr_ack) |=> arr_req);  // R11
  AST_HW_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (srwd_q && !wp_n_s) |=> ($stable(srwd_q) && $stable(bp_q)));  // R7
  AST_PAGE_WR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    pg_wr |-> (cmd_q == OPC_PROG));  // R8

endmodule

// File: rtl/sfc_sr_shifter.sv
module sfc_sr_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck_fall,
  input  logic       cs_act,
  input  logic       rdsr_active,
  input  logic [7:0] status,
  output logic       miso,
  output logic       miso_oe
);
  logic [2:0] idx_q;
  logic [7:0] snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= 3'd7;
      snap_q  <= '0;
      miso    <= 1'b0;
      miso_oe <= 1'b0;
    end else if (!cs_act) begin
      idx_q   <= 3'd7;
      miso    <= 1'b0;
      miso_oe <= 1'b0;
    end else if (sck_fall && rdsr_active) begin
      miso_oe <= 1'b1;
      if (idx_q == 3'd7) begin
        snap_q <= status;
        miso   <= status[7];
      end else begin
        miso   <= snap_q[idx_q];
      end
      idx_q <= idx_q - 3'd1;
    end
  end

  AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && !sck_fall) |=> $stable(miso));  // R4
  AST_OE_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !miso_oe);  // R5
  AST_OE_ONLY_RDSR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miso_oe) |-> $past(rdsr_active));  // R5

endmodule

// File: rtl/spi_flash_ctrl.sv
module spi_flash_ctrl #(
  parameter int ADDR_W      = 17,
  parameter int PAGE_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic              wp_n,
  output logic              arr_req,
  output logic [1:0]        arr_op,
  output logic [ADDR_W-1:0] arr_addr,
  input  logic              arr_ack,
  output logic              pg_clr,
  output logic              pg_wr,
  output logic [PAGE_W-1:0] pg_col,
  output logic [7:0]        pg_data
);
  logic       sck_rise, sck_fall, cs_fall, cs_rise, cs_act, mosi_s, wp_n_s;
  logic [7:0] status;
  logic       rdsr_active;

  sfc_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .wp_n(wp_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .cs_act(cs_act), .mosi_s(mosi_s),
    .wp_n_s(wp_n_s)
  );

  sfc_cmd_engine #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .cs_act(cs_act), .mosi_s(mosi_s), .wp_n_s(wp_n_s),
    .arr_ack(arr_ack), .status(status), .rdsr_active(rdsr_active),
    .arr_req(arr_req), .arr_op(arr_op), .arr_addr(arr_addr),
    .pg_clr(pg_clr), .pg_wr(pg_wr), .pg_col(pg_col), .pg_data(pg_data)
  );

  sfc_sr_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .sck_fall(sck_fall), .cs_act(cs_act),
    .rdsr_active(rdsr_active), .status(status), .miso(spi_miso),
    .miso_oe(spi_miso_oe)
  );

  AST_REQ_OP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req |-> (arr_op != 2'd0));  // R8

endmodule

// File: tb/test_spi_flash_ctrl.sv
`timescale 1ns/1ps
module test_spi_flash_ctrl;
  localparam int ADDR_W = 17;
  localparam int PAGE_W = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0, wp_n = 1'b1, arr_ack = 1'b0;
  logic spi_miso, spi_miso_oe, arr_req, pg_clr, pg_wr;
  logic [1:0] arr_op;
  logic [ADDR_W-1:0] arr_addr;
  logic [PAGE_W-1:0] pg_col;
  logic [7:0] pg_data;

  int n_chk = 0, n_err = 0;
  logic mode3 = 1'b0;

  // bench model
  logic m_srwd = 1'b0, m_wel = 1'b0;
  logic [1:0] m_bp = 2'b00;

  // page buffer capture
  logic [7:0] cap_data [0:7];
  logic [PAGE_W-1:0] cap_col [0:7];
  int cap_n = 0;

  always #2.5 clk = ~clk;

  spi_flash_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_spi_flash_ctrl (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .wp_n(wp_n), .arr_req(arr_req), .arr_op(arr_op), .arr_addr(arr_addr),
    .arr_ack(arr_ack), .pg_clr(pg_clr), .pg_wr(pg_wr), .pg_col(pg_col),
    .pg_data(pg_data)
  );

  always @(posedge clk) begin
    if (pg_clr) cap_n = 0;
    else if (pg_wr && cap_n < 8) begin
      cap_data[cap_n] = pg_data;
      cap_col[cap_n]  = pg_col;
      cap_n = cap_n + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic locked(input logic [23:0] a, input logic [1:0] bp);
    int q;
    q = int'(a[16:15]);
    if (bp == 2'b00) return 1'b0;
    return q >= (4 - (1 << (int'(bp) - 1)));
  endfunction

  function automatic logic [7:0] model_sr(input logic wip);
    return {m_srwd, 3'b000, m_bp, m_wel, wip};
  endfunction

  task automatic half();
    repeat (6) @(negedge clk);
  endtask

  task automatic fbegin(input logic m3);
    mode3 = m3;
    spi_sck = m3;
    half();
    spi_cs_n = 1'b0;
    half();
  endtask

  task automatic fend();
    if (!mode3) begin
      spi_sck = 1'b0;
      half();
    end
    spi_cs_n = 1'b1;
    half(); half(); half();
  endtask

  task automatic xbyte(input logic [7:0] tx, input int nbits, output logic [7:0] rx,
                       output logic oe_any, output logic oe_all);
    oe_any = 1'b0; oe_all = 1'b1; rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      spi_sck = 1'b0; spi_mosi = tx[i];
      half();
      rx[i] = spi_miso;
      oe_any = oe_any | spi_miso_oe;
      oe_all = oe_all & spi_miso_oe;
      spi_sck = 1'b1;
      half();
    end
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] r; logic a, c;
    xbyte(b, 8, r, a, c);
  endtask

  task automatic sendbits(input logic [7:0] b, input int n);
    logic [7:0] r; logic a, c;
    xbyte(b, n, r, a, c);
  endtask

  task automatic cmd1(input logic [7:0] op, input logic m3);
    fbegin(m3); send(op); fend();
  endtask

  task automatic cmd_addr(input logic [7:0] op, input logic [23:0] a, input logic m3);
    fbegin(m3); send(op); send(a[23:16]); send(a[15:8]); send(a[7:0]); fend();
  endtask

  task automatic wrsr(input logic [7:0] v);
    fbegin(1'b0); send(8'h01); send(v); fend();
  endtask

  task automatic prog(input logic [23:0] a, input logic [23:0] d, input int n);
    fbegin(1'b0); send(8'h02); send(a[23:16]); send(a[15:8]); send(a[7:0]);
    for (int k = 0; k < n; k++) send(d[23-8*k -: 8]);
    fend();
  endtask

  task automatic read_sr(input logic m3, output logic [7:0] s0, output logic [7:0] s1);
    logic a, c;
    fbegin(m3); send(8'h05);
    xbyte(8'h00, 8, s0, a, c);
    xbyte(8'h00, 8, s1, a, c);
    fend();
  endtask

  task automatic check_sr(input string req, input logic [7:0] exp);
    logic [7:0] s0, s1;
    read_sr(1'b0, s0, s1);
    check(req, {24'd0, s0}, {24'd0, exp});
  endtask

  task automatic ack_array();
    @(negedge clk) arr_ack = 1'b1;
    @(negedge clk) arr_ack = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    logic [7:0] s0, s1;
    logic oa, ob;
    void'($urandom(32'd20240611));
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1 reset state
    check("R1 arr_req after reset", {31'd0, arr_req}, 32'd0);
    check("R1 miso_oe after reset", {31'd0, spi_miso_oe}, 32'd0);
    check_sr("R1 status after reset", 8'h00);

    // R5 output enable only after the status opcode
    fbegin(1'b0);
    xbyte(8'h05, 8, s0, oa, ob);
    check("R5 oe during opcode", {31'd0, oa}, 32'd0);
    xbyte(8'h00, 8, s0, oa, ob);
    check("R5 oe during status", {31'd0, ob}, 32'd1);
    fend();
    check("R5 oe after deselect", {31'd0, spi_miso_oe}, 32'd0);

    // R2 R3 R4 mode 3, extra clocks after write enable ignored, repeated status
    fbegin(1'b1); send(8'h06); send(8'hFF); fend();
    read_sr(1'b1, s0, s1);
    check("R2 R3 mode3 status byte 0", {24'd0, s0}, 32'h02);
    check("R4 repeated status byte 1", {24'd0, s1}, 32'h02);
    cmd1(8'h04, 1'b0);
    check_sr("R3 write disable", 8'h00);

    // R13 status write without latch
    wrsr(8'h8C);
    check_sr("R13 write status without latch", 8'h00);

    // R6 R7
    cmd1(8'h06, 1'b0); wrsr(8'h8C);
    check_sr("R6 write status", 8'h8C);
    wp_n = 1'b0;
    cmd1(8'h06, 1'b0); wrsr(8'h00);
    check_sr("R7 hardware locked", 8'h8E);
    wp_n = 1'b1;
    wrsr(8'h00);
    check_sr("R7 unlocked by pin", 8'h00);
    cmd1(8'h06, 1'b0);
    fbegin(1'b0); send(8'h01); send(8'h0C); sendbits(8'h80, 1); fend();
    check_sr("R6 17-bit write status ignored", 8'h02);
    wrsr(8'h04);
    check_sr("R6 protect bits 01", 8'h04);

    // R10 R9 R11
    cmd1(8'h06, 1'b0);
    cmd_addr(8'hD8, 24'h018000, 1'b0);
    check("R10 locked sector erase", {31'd0, arr_req}, 32'd0);
    check_sr("R10 R13 latch kept", 8'h06);
    cmd_addr(8'hD8, 24'h010000, 1'b0);
    check("R9 sector erase req", {31'd0, arr_req}, 32'd1);
    check("R9 sector erase op", {30'd0, arr_op}, 32'd2);
    check("R9 sector erase addr", {15'd0, arr_addr}, 32'h10000);
    check_sr("R11 busy status", 8'h07);
    cmd1(8'h04, 1'b0);
    check_sr("R11 write disable while busy", 8'h07);
    ack_array();
    check("R11 req dropped", {31'd0, arr_req}, 32'd0);
    check_sr("R11 done clears latch", 8'h04);

    cmd1(8'h06, 1'b0); cmd1(8'hC7, 1'b0);
    check("R9 bulk erase locked", {31'd0, arr_req}, 32'd0);
    wrsr(8'h00);
    cmd1(8'h06, 1'b0);
    fbegin(1'b0); send(8'hC7); sendbits(8'h00, 1); fend();
    check("R9 bulk erase 9 bits", {31'd0, arr_req}, 32'd0);
    cmd1(8'hC7, 1'b1);
    check("R9 bulk erase req", {31'd0, arr_req}, 32'd1);
    check("R9 bulk erase op", {30'd0, arr_op}, 32'd3);
    ack_array();
    check_sr("R11 after bulk", 8'h00);

    // R8 page program with column wrap
    cmd1(8'h06, 1'b0);
    prog(24'h00027E, 24'hA1B2C3, 3);
    check("R8 program req", {31'd0, arr_req}, 32'd1);
    check("R8 program op", {30'd0, arr_op}, 32'd1);
    check("R8 program addr", {15'd0, arr_addr}, 32'h0027E);
    check("R8 byte count", cap_n, 32'd3);
    check("R8 col 0", {25'd0, cap_col[0]}, 32'h7E);
    check("R8 col wrap", {25'd0, cap_col[2]}, 32'h00);
    check("R8 data 2", {24'd0, cap_data[2]}, 32'hC3);
    ack_array();
    cmd1(8'h06, 1'b0);
    fbegin(1'b0); send(8'h02); send(8'h00); send(8'h01); send(8'h00);
    send(8'h55); sendbits(8'hE0, 3); fend();
    check("R8 mid-byte deselect", {31'd0, arr_req}, 32'd0);
    check_sr("R8 latch kept", 8'h02);

    // R12 unknown opcode
    cmd1(8'h04, 1'b0);
    fbegin(1'b0); send(8'h9F); send(8'h06); fend();
    check_sr("R12 unknown opcode ignored", 8'h00);

    // random commands against the bench model
    for (int it = 0; it < 40; it++) begin
      logic [2:0] sel;
      logic [7:0] v;
      logic [23:0] a, d;
      logic er;
      logic [1:0] eop;
      logic [16:0] ea;
      int nb;
      sel = 3'($urandom_range(0, 6));
      v = 8'($urandom);
      a = 24'($urandom);
      d = 24'($urandom);
      nb = $urandom_range(1, 3);
      wp_n = ($urandom_range(0, 3) != 0);
      er = 1'b0; eop = 2'd0; ea = '0;
      if (sel >= 3'd2 && sel <= 3'd5 && $urandom_range(0, 1) == 1) begin
        cmd1(8'h06, 1'($urandom_range(0, 1)));
        m_wel = 1'b1;
      end
      case (sel)
        3'd0: begin cmd1(8'h06, 1'b1); m_wel = 1'b1; end
        3'd1: begin cmd1(8'h04, 1'b0); m_wel = 1'b0; end
        3'd2: begin
          wrsr(v);
          if (m_wel && !(m_srwd && !wp_n)) begin
            m_srwd = v[7]; m_bp = v[3:2]; m_wel = 1'b0;
          end
        end
        3'd3: begin
          cmd_addr(8'hD8, a, 1'($urandom_range(0, 1)));
          if (m_wel && !locked(a, m_bp)) begin er = 1'b1; eop = 2'd2; ea = a[16:0]; end
        end
        3'd4: begin
          cmd1(8'hC7, 1'b0);
          if (m_wel && m_bp == 2'b00) begin er = 1'b1; eop = 2'd3; end
        end
        3'd5: begin
          prog(a, d, nb);
          if (m_wel && !locked(a, m_bp)) begin er = 1'b1; eop = 2'd1; ea = a[16:0]; end
        end
        default: begin fbegin(1'b0); send(8'hAB); send(v); fend(); end
      endcase
      check("R9 R10 R13 random req", {31'd0, arr_req}, {31'd0, er});
      if (er) begin
        check("R9 R8 random op", {30'd0, arr_op}, {30'd0, eop});
        check("R9 R8 random addr", {15'd0, arr_addr}, {15'd0, ea});
        if (eop == 2'd1) check("R8 random byte count", cap_n, nb);
        ack_array();
        m_wel = 1'b0;
      end
      check_sr("R6 R7 R11 random status", model_sr(1'b0));
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule